// File: doc/BRIEF.md
# Oversampled Digital Output Channel with Fallback Modes

This block drives one digital output pin from a word of oversampled bits that arrives once per communication cycle. Each cycle brings `SAMPLES` bits. The block plays them out one after another, bit 0 first. Each bit is held for `SUB_TICKS` clocks, so the samples spread evenly across the cycle period.

A communication watchdog is reloaded by every good cycle. If no good cycle arrives for `WD_TICKS` clocks, the watchdog expires. An upstream cycle-counter monitor can also flag a cycle as erroneous; such a cycle carries no usable data. A per-channel configuration byte chooses what is driven in each of these two fault situations. The choices are a constant level, holding the last bit, continuing or replaying the stored samples, a toggling level, or a released (high-impedance) output.

The core is a four-state controller:

- **PLAY** plays the stored samples.
- **HOLD** keeps the final sample once the cycle has been played out.
- **CCERR** applies the counter-error behaviour.
- **WDOG** applies the watchdog behaviour. It is also the state entered from reset.

Its transitions are:

- **LOAD**: a good strobe moves any state to PLAY.
- **DRAIN**: PLAY moves to HOLD after the last sample.
- **MISS**: a failing strobe moves PLAY, HOLD or CCERR to CCERR.
- **TIMEOUT**: watchdog expiry moves any non-WDOG state to WDOG.

When the configuration bytes of two channels are written as one 16-bit word, both channels change together.

Top module: `ovs_out_chan`

## Requirements
- R1: While reset is asserted and right after it is released, the channel is in the watchdog-fallback state and drives the watchdog behaviour selected by `cfg`; with `cfg` = 0 this is level 0 with the output enabled.
- R2: A strobe with `cyc_fail` low stores `cyc_bits` and plays it out. Bit i is driven with `drv_oe` high from clock `i*SUB_TICKS+1` to clock `(i+1)*SUB_TICKS` after the strobe edge.
- R3: When all samples of a cycle have been played and no new strobe has arrived, `cyc_bits[SAMPLES-1]` of the stored cycle stays on the output until another event occurs.
- R4: The watchdog expires exactly `WD_TICKS` clocks after the last good strobe. From the next clock the watchdog behaviour is driven. Failing strobes do not reload it.
- R5: `cfg` bit 0 enables the custom behaviours, bits 3:1 hold the counter-error code and bits 6:4 hold the watchdog code. With bit 0 low, both fault situations drive level 0 with the output enabled.
- R6: Code 000 drives 0 and code 001 drives 1. The unused codes 110 and 111 also drive 0. All of these keep `drv_oe` high.
- R7: Code 010 drives bit `SAMPLES-1` of the last stored good cycle.
- R8: Code 011 plays the stored samples, restarting at bit 0 when the fault is entered and wrapping after the last bit. For a counter error this continues the possibly stale buffer. After a timeout it replays the last good cycle.
- R9: Code 100 drives 0 for the first `SUB_TICKS` clocks after the fault is entered, then toggles every `SUB_TICKS` clocks.
- R10: Code 101 deasserts `drv_oe` and drives `drv_lvl` low. `drv_oe` is never low in any other situation.
- R11: The watchdog behaviour outranks the counter-error behaviour. A failing strobe received in the watchdog state changes nothing. An expiry during a counter error switches the output to the watchdog code.
- R12: A good strobe in any state, including mid-cycle, restarts playback at bit 0 of the new data and reloads the watchdog.
- R13: A failing strobe outside the watchdog state starts the counter-error behaviour on the next clock. The sample framing restarts, and the state persists until a good strobe or a watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One-clock strobe marking a new communication cycle |
| cyc_fail | input | 1 | Counter-monitor error for the cycle marked by `cyc_stb` |
| cyc_bits | input | SAMPLES | Oversampled bits of the cycle, bit 0 played first |
| cfg | input | 8 | Channel configuration byte; bit 7 is unused |
| drv_lvl | output | 1 | Logic level for the output stage |
| drv_oe | output | 1 | Output-stage enable; low releases the pin |

## Verification
The assertions assume that `cyc_fail` matters only in clocks where `cyc_stb` is high, and that `cyc_stb` is a single-clock pulse. They also assume that `cfg` is held steady by its writer: it is combinational into the output, so the checked levels follow whatever code is present. The stimulus moves all inputs just after a rising edge and raises the strobe for exactly one clock at a time. It changes `cfg` only right before a good strobe. This keeps every configuration change aligned with a known playback phase, so the arithmetic reference in the bench predicts each level without ambiguity.

// File: rtl/ovs_pkg.sv
`timescale 1ns/1ps
package ovs_pkg;

    typedef enum logic [1:0] {
        ST_PLAY  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_CCERR = 2'd2,
        ST_WDOG  = 2'd3
    } ovs_state_e;

    // Fallback codes (R6..R10); values are fixed by the configuration encoding.
    typedef enum logic [2:0] {
        FB_LOW    = 3'd0,
        FB_HIGH   = 3'd1,
        FB_HOLD   = 3'd2,
        FB_STREAM = 3'd3,
        FB_TOGGLE = 3'd4,
        FB_FLOAT  = 3'd5,
        FB_RSV6   = 3'd6,
        FB_RSV7   = 3'd7
    } ovs_fb_e;

    typedef struct packed {
        ovs_fb_e on_count_err;
        ovs_fb_e on_timeout;
    } ovs_fb_sel_t;

    // R5: bit 0 enables custom codes, bits 3:1 count error, bits 6:4 timeout.
    function automatic ovs_fb_sel_t ovs_decode(input logic [6:0] c);
        ovs_fb_sel_t r;
        if (c[0]) begin
            r.on_count_err = ovs_fb_e'(c[3:1]);
            r.on_timeout   = ovs_fb_e'(c[6:4]);
        end else begin
            r.on_count_err = FB_LOW;
            r.on_timeout   = FB_LOW;
        end
        return r;
    endfunction

endpackage

// File: rtl/ovs_tick_gen.sv
`timescale 1ns/1ps
module ovs_tick_gen #(
    parameter int SAMPLES   = 10,
    parameter int SUB_TICKS = 4,
    localparam int IW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
    localparam int SW = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [IW-1:0] idx,
    output logic          alt,
    output logic          last
);

    logic [SW-1:0] sub_q;
    logic [IW-1:0] idx_q;
    logic          alt_q;
    logic          tick;

    assign tick = (sub_q == SW'(SUB_TICKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sub_q <= '0;
            idx_q <= '0;
            alt_q <= 1'b0;
        end else if (tick) begin
            sub_q <= '0;
            idx_q <= (idx_q == IW'(SAMPLES - 1)) ? '0 : idx_q + 1'b1;
            alt_q <= ~alt_q;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign alt  = alt_q;
    assign last = tick && (idx_q == IW'(SAMPLES - 1));

endmodule

// File: rtl/ovs_wdog.sv
`timescale 1ns/1ps
module ovs_wdog #(
    parameter int WD_TICKS = 1000,
    localparam int WW = $clog2(WD_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic run,
    output logic expire
);

    logic [WW-1:0] cnt_q;

    // R4: counts clocks since the last reload; frozen while expired.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            cnt_q <= '0;
        end else if (run && cnt_q != WW'(WD_TICKS - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == WW'(WD_TICKS - 1));

endmodule

// File: rtl/ovs_fsm.sv
`timescale 1ns/1ps
module ovs_fsm
    import ovs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       good,
    input  logic       bad,
    input  logic       expire,
    input  logic       last,
    output ovs_state_e state,
    output logic       restart
);

    ovs_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_WDOG;             // R1
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (good) begin
            st_d = ST_PLAY;              // LOAD, R12
        end else if (expire) begin
            st_d = ST_WDOG;              // TIMEOUT, R4 / R11
        end else begin
            unique case (st_q)
                ST_PLAY: begin
                    if (bad)       st_d = ST_CCERR;   // MISS, R13
                    else if (last) st_d = ST_HOLD;    // DRAIN, R3
                end
                ST_HOLD:  if (bad) st_d = ST_CCERR;
                ST_CCERR: st_d = ST_CCERR;
                ST_WDOG:  st_d = ST_WDOG;             // R11: failing strobe ignored
            endcase
        end
    end

    assign state   = st_q;
    assign restart = good || expire || (bad && st_q != ST_WDOG);

endmodule

// File: rtl/ovs_level_sel.sv
`timescale 1ns/1ps
module ovs_level_sel
    import ovs_pkg::*;
#(
    parameter int SAMPLES = 10,
    localparam int IW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
    input  ovs_state_e         state,
    input  ovs_fb_sel_t        sel,
    input  logic [SAMPLES-1:0] buf_bits,
    input  logic [IW-1:0]      idx,
    input  logic               alt,
    output logic               lvl,
    output logic               oe
);

    ovs_fb_e mode;
    logic    fault;

    always_comb begin
        lvl   = 1'b0;
        oe    = 1'b1;
        fault = 1'b0;
        mode  = FB_LOW;
        unique case (state)
            ST_PLAY:  lvl = buf_bits[idx];                    // R2
            ST_HOLD:  lvl = buf_bits[SAMPLES-1];              // R3
            ST_CCERR: begin fault = 1'b1; mode = sel.on_count_err; end
            ST_WDOG:  begin fault = 1'b1; mode = sel.on_timeout;   end
        endcase
        if (fault) begin
            unique case (mode)
                FB_LOW, FB_RSV6, FB_RSV7: lvl = 1'b0;          // R6
                FB_HIGH:   lvl = 1'b1;                         // R6
                FB_HOLD:   lvl = buf_bits[SAMPLES-1];          // R7
                FB_STREAM: lvl = buf_bits[idx];                // R8
                FB_TOGGLE: lvl = alt;                          // R9
                FB_FLOAT:  begin lvl = 1'b0; oe = 1'b0; end    // R10
            endcase
        end
    end

endmodule

// File: rtl/ovs_out_chan.sv
`timescale 1ns/1ps
module ovs_out_chan
    import ovs_pkg::*;
#(
    parameter int SAMPLES   = 10,
    parameter int SUB_TICKS = 20000,
    parameter int WD_TICKS  = 10000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_stb,
    input  logic               cyc_fail,
    input  logic [SAMPLES-1:0] cyc_bits,
    input  logic [7:0]         cfg,
    output logic               drv_lvl,
    output logic               drv_oe
);

    localparam int IW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

    logic               good, bad, expire, last, restart, alt;
    logic [IW-1:0]      idx;
    logic [SAMPLES-1:0] buf_q;
    ovs_state_e         st_q;
    ovs_fb_sel_t        sel;
    logic               cfg_unused;

    assign good       = cyc_stb && !cyc_fail;
    assign bad        = cyc_stb && cyc_fail;
    assign sel        = ovs_decode(cfg[6:0]);
    assign cfg_unused = cfg[7];

    // Sample buffer holds the last good cycle (R2, R7, R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (good) begin
            buf_q <= cyc_bits;
        end
    end

    ovs_tick_gen #(.SAMPLES(SAMPLES), .SUB_TICKS(SUB_TICKS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .idx     (idx),
        .alt     (alt),
        .last    (last)
    );

    ovs_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (good),
        .run    (st_q != ST_WDOG),
        .expire (expire)
    );

    ovs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .good    (good),
        .bad     (bad),
        .expire  (expire),
        .last    (last),
        .state   (st_q),
        .restart (restart)
    );

    ovs_level_sel #(.SAMPLES(SAMPLES)) u_sel (
        .state    (st_q),
        .sel      (sel),
        .buf_bits (buf_q),
        .idx      (idx),
        .alt      (alt),
        .lvl      (drv_lvl),
        .oe       (drv_oe)
    );

endmodule

// File: rtl/ovs_out_chan_chk.sv
`timescale 1ns/1ps
module ovs_out_chan_chk
    import ovs_pkg::*;
#(
    parameter int WD_TICKS = 1000,
    localparam int WW = $clog2(WD_TICKS + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_stb,
    input logic       cyc_fail,
    input logic       first_bit,
    input logic [6:0] cfg,
    input logic       drv_lvl,
    input logic       drv_oe,
    input ovs_state_e state
);

    // Clocks since the last good strobe, saturating at WD_TICKS.
    logic [WW-1:0] since_good;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_good <= WW'(WD_TICKS);
        end else if (cyc_stb && !cyc_fail) begin
            since_good <= '0;
        end else if (since_good < WW'(WD_TICKS)) begin
            since_good <= since_good + 1'b1;
        end
    end

    a_r2_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !cyc_fail) |=> (drv_oe && drv_lvl == $past(first_bit)));

    a_r4_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (since_good >= WW'(WD_TICKS)) |-> (state == ST_WDOG));

    a_r4_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (since_good < WW'(WD_TICKS)) |-> (state != ST_WDOG));

    a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> $stable(drv_lvl));

    a_r5_plain_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[0] && (state == ST_CCERR || state == ST_WDOG)) |-> (drv_oe && !drv_lvl));

    a_r10_float_only: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_oe |-> (cfg[0] && (cfg[3:1] == 3'd5 || cfg[6:4] == 3'd5)));

    a_r11_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDOG && cyc_stb && cyc_fail) |=> (state == ST_WDOG));

endmodule

bind ovs_out_chan ovs_out_chan_chk #(.WD_TICKS(WD_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_stb   (cyc_stb),
    .cyc_fail  (cyc_fail),
    .first_bit (cyc_bits[0]),
    .cfg       (cfg[6:0]),
    .drv_lvl   (drv_lvl),
    .drv_oe    (drv_oe),
    .state     (st_q)
);

// File: tb/sim_ovs_out_chan.sv
`timescale 1ns/1ps
module sim_ovs_out_chan;

    localparam int S   = 10;
    localparam int SUB = 3;
    localparam int WD  = 100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stb = 1'b0;
    logic         fail = 1'b0;
    logic [S-1:0] bits = '0;
    logic [7:0]   cfg = 8'h00;
    logic         drv_lvl, drv_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;

    always #2 clk = ~clk;

    ovs_out_chan #(.SAMPLES(S), .SUB_TICKS(SUB), .WD_TICKS(WD)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(stb), .cyc_fail(fail),
        .cyc_bits(bits), .cfg(cfg), .drv_lvl(drv_lvl), .drv_oe(drv_oe)
    );

    // Reference: 0 play, 1 hold, 2 counter error, 3 watchdog.
    int           m_st, m_pos, m_wd;
    logic [S-1:0] m_buf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 3; m_pos <= 0; m_wd <= 0; m_buf <= '0;
        end else if (stb && !fail) begin
            m_st <= 0; m_pos <= 0; m_wd <= 0; m_buf <= bits;
        end else if (m_st != 3 && m_wd == WD - 1) begin
            m_st <= 3; m_pos <= 0;
        end else begin
            if (m_st != 3) m_wd <= m_wd + 1;
            if (stb && fail && m_st != 3) begin
                m_st <= 2; m_pos <= 0;
            end else begin
                m_pos <= m_pos + 1;
                if (m_st == 0 && m_pos == S * SUB - 1) m_st <= 1;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            int k, code;
            logic e_lvl, e_oe;
            string tag;
            k = m_pos / SUB;
            e_oe = 1'b1;
            e_lvl = 1'b0;
            case (m_st)
                0: begin e_lvl = m_buf[k % S]; tag = "R2/R12"; end
                1: begin e_lvl = m_buf[S-1];   tag = "R3"; end
                default: begin
                    tag = (m_st == 2) ? "R13" : "R4/R11";
                    code = !cfg[0] ? 0 : (m_st == 2) ? int'(cfg[3:1]) : int'(cfg[6:4]);
                    if (!cfg[0]) tag = {tag, " R5"};
                    case (code)
                        1: begin e_lvl = 1'b1; tag = {tag, " R6"}; end
                        2: begin e_lvl = m_buf[S-1]; tag = {tag, " R7"}; end
                        3: begin e_lvl = m_buf[k % S]; tag = {tag, " R8"}; end
                        4: begin e_lvl = k[0]; tag = {tag, " R9"}; end
                        5: begin e_oe = 1'b0; tag = {tag, " R10"}; end
                        default: tag = {tag, " R6"};
                    endcase
                end
            endcase
            n_cmp++;
            if (drv_lvl !== e_lvl || drv_oe !== e_oe) begin
                n_bad++;
                $display("FAIL %s cfg=%02h: lvl/oe got %b%b expected %b%b at %0t",
                         tag, cfg, drv_lvl, drv_oe, e_lvl, e_oe, $time);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse(input logic f, input logic [S-1:0] b);
        stb = 1'b1; fail = f; bits = b;
        wait_clk(1);
        stb = 1'b0; fail = 1'b0;
    endtask

    task automatic direct(input string tag, input logic el, input logic eo);
        @(negedge clk);
        n_cmp++;
        if (drv_lvl !== el || drv_oe !== eo) begin
            n_bad++;
            $display("FAIL %s: lvl/oe got %b%b expected %b%b", tag, drv_lvl, drv_oe, el, eo);
        end
        @(posedge clk); #1;
    endtask

    function automatic logic [S-1:0] pat(input int n);
        return S'(n * 709 + 419) ^ S'(n << 3);
    endfunction

    task automatic scenario(input logic [7:0] c, input int seed);
        cfg = c;
        pulse(1'b0, pat(seed));        // R2
        wait_clk(12);
        pulse(1'b0, pat(seed + 1));    // R12 mid-cycle reload
        wait_clk(40);                  // R3 drain to hold
        pulse(1'b1, pat(seed + 2));    // R13 data must not be stored
        wait_clk(45);                  // R8 wrap, R9 toggling
        pulse(1'b0, pat(seed + 3));
        wait_clk(5);
        pulse(1'b1, '0);
        wait_clk(WD + 10);             // R4 / R11 expiry during counter error
        pulse(1'b1, '1);               // R11 ignored in watchdog
        wait_clk(20);
        pulse(1'b0, pat(seed + 4));    // R12 recovery
        wait_clk(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cfg = 8'h13;                   // custom, watchdog code 001
        wait_clk(4);
        direct("R1 in reset", 1'b1, 1'b1);
        rst_n = 1'b1;
        direct("R1 after reset wd=001", 1'b1, 1'b1);
        cfg = 8'h00;
        direct("R1 after reset cfg=0", 1'b0, 1'b1);
        cfg = 8'h51;                   // custom, watchdog code 101
        direct("R10 float from reset", 1'b0, 1'b0);
        chk_on = 1'b1;
        for (int w = 0; w < 8; w++) begin
            for (int e = 0; e < 8; e++) begin
                scenario({1'b0, 3'(w), 3'(e), 1'b1}, w * 8 + e);
            end
        end
        scenario(8'h5A, 70);           // R5: codes present but not enabled
        scenario(8'hFE, 71);           // R5
        chk_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule